// File: doc/BRIEF.md
# Module Standard Register Responder

Every firmware module on a shared register bus carries this front end. A bus request carries an 8-bit board-select field, a 16-bit address, a write flag and 32-bit write data. One select bit belongs to each module. The responder acknowledges only those requests whose select field includes its own bit. It answers the three highest addresses of the map itself and passes every other address on to the module's own register file.

At the top of the map, a read and a write to the same address reach different things. A read of the highest address returns the code version, encoded as 100 × major + minor. A write there asks for a warm reboot, but only when all eight select bits are set. A read of the next address down returns the module's identity code. A write there resets every selected module and, when the select field is all ones, also resets the whole system. The third address reads back the module's status word.

Reset and reboot requests leave as single-cycle pulses. Each pulse comes one cycle after the acknowledge, so the acknowledge still reaches the bus before the module goes into reset.

Top module: `stdreg_responder`

## Requirements
- R1: `rsp_ack` is high exactly one cycle after a cycle in which `req_valid` is high and `req_sel[MY_BIT]` is set. A request without the module's bit gets no acknowledge, no read data and no pulse.
- R2: A read of address 0xFFFF returns `100*VER_MAJOR + VER_MINOR` on `rsp_rdata` in the acknowledge cycle.
- R3: A read of address 0xFFFE returns the identity code of the module's select bit. Bits 0 to 4 give 201 to 205, bit 7 gives 208, and the spare bits 5 and 6 give 0.
- R4: A read of address 0xFFFD returns `status_in` as sampled in the request cycle.
- R5: A write to 0xFFFF with select field 0xFF raises `reboot_pulse` for exactly one cycle, one cycle after the acknowledge. The write data is discarded.
- R6: A write to 0xFFFF with any other select pattern that includes the module's bit is acknowledged, and `reboot_pulse` stays low.
- R7: A write to 0xFFFE raises `mod_reset_pulse` for one cycle, one cycle after the acknowledge, whatever the other select bits are. `sys_reset_pulse` rises with it only when the select field is 0xFF.
- R8: Any address below 0xFFFD raises `local_req` combinationally in the request cycle. A read of such an address returns `local_rdata` as sampled in that cycle. No pulse follows.
- R9: A write to 0xFFFD, and any read at all, is acknowledged without any pulse. A read acknowledge returns 0 on `rsp_rdata` when the read is not answered (writes return 0).
- R10: While `rst_n` is low, and in the first cycle after it, all outputs are 0 when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_sel | input | 8 | Board-select field, one bit per module |
| req_addr | input | 16 | Register address |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| status_in | input | 32 | Module status word |
| local_rdata | input | 32 | Read data from the module's own register file |
| local_req | output | 1 | Request goes to the module's own register file |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |
| mod_reset_pulse | output | 1 | One-cycle module reset |
| sys_reset_pulse | output | 1 | One-cycle system-wide reset |
| reboot_pulse | output | 1 | One-cycle warm reboot request |

## Verification
The bench sweeps all 256 select patterns against each of the standard addresses, as both reads and writes. This sweep separates the module's own bit from the other seven. It also separates the all-ones pattern, which alone may trigger a system reset or a reboot, from patterns that only reset the module or do nothing. Local addresses just below and far below the standard block show that the pass-through boundary sits at 0xFFFD. Changing status and local data values show that read data is sampled in the request cycle.

// File: rtl/stdreg_pkg.sv
package stdreg_pkg;

  typedef enum logic [1:0] {
    KIND_LOCAL   = 2'd0,
    KIND_VERSION = 2'd1,
    KIND_IDENT   = 2'd2,
    KIND_STATUS  = 2'd3
  } reg_kind_e;

  // Version word: hundreds carry the major number, the rest the minor.
  function automatic logic [31:0] version_code(input int unsigned major, input int unsigned minor);
    return 32'(major * 100 + minor);
  endfunction

  // Identity code for the module owning a given select bit; spares read 0.
  function automatic logic [31:0] ident_code(input int unsigned bit_idx);
    if (bit_idx <= 4)       return 32'(201 + bit_idx);
    else if (bit_idx == 7)  return 32'd208;
    else                    return 32'd0;
  endfunction

endpackage

// File: rtl/stdreg_sel_decode.sv
module stdreg_sel_decode #(
  parameter int SEL_W  = 8,
  parameter int MY_BIT = 4
) (
  input  logic [SEL_W-1:0] sel,
  output logic             own_hit,
  output logic             all_hit
);
  assign own_hit = sel[MY_BIT];
  assign all_hit = &sel;
endmodule

// File: rtl/stdreg_addr_decode.sv
module stdreg_addr_decode
  import stdreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  localparam logic [ADDR_W-1:0] A_VER  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_ID   = A_VER - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = A_VER - ADDR_W'(2);

  always_comb begin
    if (addr == A_VER)       kind = KIND_VERSION;
    else if (addr == A_ID)   kind = KIND_IDENT;
    else if (addr == A_STAT) kind = KIND_STATUS;
    else                     kind = KIND_LOCAL;
  end
endmodule

// File: rtl/stdreg_pulse_stage.sv
module stdreg_pulse_stage #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic [N-1:0] pulse
);
  // One register per pulse: each request flag becomes a pulse a cycle later.
  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= pend[i];
    end
  end
endmodule

// File: rtl/stdreg_responder.sv
module stdreg_responder
  import stdreg_pkg::*;
#(
  parameter int SEL_W     = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MY_BIT    = 4,
  parameter int VER_MAJOR = 2,
  parameter int VER_MINOR = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] local_rdata,
  output logic              local_req,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mod_reset_pulse,
  output logic              sys_reset_pulse,
  output logic              reboot_pulse
);
  localparam logic [DATA_W-1:0] VER_WORD = DATA_W'(version_code(VER_MAJOR, VER_MINOR));
  localparam logic [DATA_W-1:0] ID_WORD  = DATA_W'(ident_code(MY_BIT));

  logic      own_hit, all_hit, req_hit;
  reg_kind_e kind;
  logic      wr_ident, wr_version;
  logic [DATA_W-1:0] rd_mux;
  logic      pend_mod, pend_sys, pend_boot;
  logic [2:0] pulses;

  stdreg_sel_decode #(.SEL_W(SEL_W), .MY_BIT(MY_BIT)) u_sel (
    .sel(req_sel), .own_hit(own_hit), .all_hit(all_hit)
  );

  stdreg_addr_decode #(.ADDR_W(ADDR_W)) u_addr (
    .addr(req_addr), .kind(kind)
  );

  // Named request events, shared by the logic and the assertions.
  assign req_hit    = req_valid & own_hit;
  assign wr_ident   = req_hit & req_wr & (kind == KIND_IDENT);
  assign wr_version = req_hit & req_wr & (kind == KIND_VERSION);
  assign local_req  = req_hit & (kind == KIND_LOCAL);

  always_comb begin
    unique case (kind)
      KIND_VERSION: rd_mux = VER_WORD;
      KIND_IDENT:   rd_mux = ID_WORD;
      KIND_STATUS:  rd_mux = status_in;
      default:      rd_mux = local_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
      pend_mod  <= 1'b0;
      pend_sys  <= 1'b0;
      pend_boot <= 1'b0;
    end else begin
      rsp_ack   <= req_hit;
      rsp_rdata <= (req_hit && !req_wr) ? rd_mux : '0;
      pend_mod  <= wr_ident;
      pend_sys  <= wr_ident & all_hit;
      pend_boot <= wr_version & all_hit;
    end
  end

  // The req_wdata is intentionally unused: standard writes discard data.
  logic unused_wdata;
  assign unused_wdata = ^req_wdata;

  stdreg_pulse_stage #(.N(3)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .pend({pend_boot, pend_sys, pend_mod}),
    .pulse(pulses)
  );
  assign mod_reset_pulse = pulses[0];
  assign sys_reset_pulse = pulses[1];
  assign reboot_pulse    = pulses[2];

  // ---------------- assertions ----------------
  assert_ack_needs_own_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(req_valid && req_sel[MY_BIT]));

  assert_reboot_needs_broadcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_pulse |-> ($past(rsp_ack) && $past(&req_sel, 2) && $past(req_wr, 2)));

  assert_sys_implies_mod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_pulse |-> mod_reset_pulse);

  assert_mod_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset_pulse |-> $past(rsp_ack));

  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reboot_pulse, mod_reset_pulse}));

  assert_local_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    local_req |-> ##2 !(reboot_pulse || mod_reset_pulse || sys_reset_pulse));

endmodule

// File: tb/stdreg_responder_tb.sv
module stdreg_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MY_BIT = 4;
  localparam int VMAJ = 2;
  localparam int VMIN = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_sel = '0;
  logic [15:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] status_in = 32'h0000_0000;
  logic [31:0] local_rdata;
  logic        local_req, rsp_ack, mod_reset_pulse, sys_reset_pulse, reboot_pulse;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign local_rdata = {req_addr, ~req_addr} ^ 32'h5A5A_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  stdreg_responder #(.MY_BIT(MY_BIT), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
    .status_in(status_in), .local_rdata(local_rdata), .local_req(local_req),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .mod_reset_pulse(mod_reset_pulse),
    .sys_reset_pulse(sys_reset_pulse), .reboot_pulse(reboot_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ident(input int b);
    case (b)
      0: return 201; 1: return 202; 2: return 203; 3: return 204;
      4: return 205; 7: return 208; default: return 0;
    endcase
  endfunction

  // One bus transaction: drive, check ack/data, then check pulses.
  task automatic txn(input logic [7:0] sel, input logic [15:0] addr, input logic wr,
                     input logic [31:0] wd);
    logic hit, is_local, e_mod, e_sys, e_boot;
    logic [31:0] e_data;
    hit      = sel[MY_BIT];
    is_local = addr < 16'hFFFD;
    e_mod    = hit && wr && addr == 16'hFFFE;
    e_sys    = e_mod && sel == 8'hFF;
    e_boot   = hit && wr && addr == 16'hFFFF && sel == 8'hFF;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_addr = addr; req_wr = wr; req_wdata = wd;
    if (!hit || wr) e_data = 0;
    else if (addr == 16'hFFFF) e_data = VMAJ * 100 + VMIN;
    else if (addr == 16'hFFFE) e_data = exp_ident(MY_BIT);
    else if (addr == 16'hFFFD) e_data = status_in;
    else e_data = {addr, ~addr} ^ 32'h5A5A_0000;
    #1;
    check("R8 local_req", 32'(local_req), 32'(hit && is_local));
    @(negedge clk);
    req_valid = 1'b0; req_sel = '0; req_addr = '0; req_wr = 1'b0;
    check("R1 ack", 32'(rsp_ack), 32'(hit));
    if (!wr) begin
      if (addr == 16'hFFFF)      check("R2 version", rsp_rdata, e_data);
      else if (addr == 16'hFFFE) check("R3 ident", rsp_rdata, e_data);
      else if (addr == 16'hFFFD) check("R4 status", rsp_rdata, e_data);
      else                       check("R8 local data", rsp_rdata, e_data);
    end
    check("R9 no early pulse", 32'({mod_reset_pulse, sys_reset_pulse, reboot_pulse}), 0);
    @(negedge clk);
    check("R7 mod reset", 32'(mod_reset_pulse), 32'(e_mod));
    check("R7 sys reset", 32'(sys_reset_pulse), 32'(e_sys));
    if (addr == 16'hFFFF && wr && sel != 8'hFF)
      check("R6 reboot suppressed", 32'(reboot_pulse), 0);
    else
      check("R5 reboot", 32'(reboot_pulse), 32'(e_boot));
    @(negedge clk);
    check("R5 single cycle", 32'({mod_reset_pulse, sys_reset_pulse, reboot_pulse}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset ack", 32'(rsp_ack), 0);
    check("R10 reset data", rsp_rdata, 0);
    check("R10 reset pulses", 32'({mod_reset_pulse, sys_reset_pulse, reboot_pulse, local_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", 32'({rsp_ack, mod_reset_pulse, sys_reset_pulse, reboot_pulse}), 0);

    for (int s = 0; s < 256; s++) begin
      status_in = 32'(s) * 32'h0101_0101 ^ 32'hC3;
      txn(8'(s), 16'hFFFF, 1'b0, 0);
      txn(8'(s), 16'hFFFE, 1'b0, 0);
      txn(8'(s), 16'hFFFD, 1'b0, 0);
      txn(8'(s), 16'hFFFF, 1'b1, 32'hDEAD_0000 | 32'(s));
      txn(8'(s), 16'hFFFE, 1'b1, 32'(s));
      txn(8'(s), 16'hFFFD, 1'b1, 32'(s));
    end
    for (int a = 0; a < 8; a++) begin
      txn(8'h10, 16'hFFFC - 16'(a), 1'b0, 0);
      txn(8'h10, 16'(a * 16'h1234), 1'b1, 32'(a));
      txn(8'hEF, 16'h0100 + 16'(a), 1'b0, 0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule